// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block supplies the read-path behaviour of a byte-wide parallel flash while an internal program or erase is running. A one-cycle start pulse carries the operation kind and the data byte being written. A cycle-count timer then stands in for the internal write time. For that time the block replaces normal array read data with status bits and raises a busy flag.

While the block is busy, bit 7 of a read holds the data-polling value. For a program it is the inverse of bit 7 of the written byte, and for either erase it is 0. Bit 6 holds a toggle value: it reads 1 on the first busy read and flips after every completed read. Bits 5 to 0 read 0. When the block is idle, reads pass the array data through unchanged. The read port is an active-low chip enable and output enable pair. The bus is driven only while both are low.

The controller is a three-state machine:
- ST_IDLE (no operation).
- ST_PROG (program in progress).
- ST_ERASE (sector or chip erase in progress).

Its transitions are:
- ST_IDLE to ST_PROG on an accepted start of kind program.
- ST_IDLE to ST_ERASE on an accepted start of kind sector or chip erase.
- ST_PROG or ST_ERASE back to ST_IDLE in the cycle in which the timer reaches zero.

Each busy state holds until then.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the block is idle: busy is 0, and reads return array data.
- R2: dq_oe is 1 only while ce_n and oe_n are both 0. Whenever dq_oe is 0, dq_out is 0, including while busy.
- R3: While idle, a read returns arr_rdata unchanged.
- R4: While a program is busy, bit 7 of every read is the inverse of bit 7 of the latched op_data.
- R5: While a sector or chip erase is busy, bit 7 of every read is 0.
- R6: While busy, bit 6 of the first read after the start is 1. Bit 6 flips after each read that completes, that is, when ce_n or oe_n rises.
- R7: While busy, bits 5 to 0 of a read are 0.
- R8: busy rises on the clock edge that accepts op_start. It stays high for exactly PROG_CYCLES, SECT_CYCLES or CHIP_CYCLES cycles, for op_kind values 2'b00, 2'b01 and 2'b10 respectively.
- R9: op_start while busy is ignored. The running kind, its status value and its remaining duration do not change.
- R10: After completion, reads return array data, so bit 6 no longer toggles. The next operation restarts the toggle at 1, whatever value the toggle held at the end of the previous operation.
- R11: op_kind 2'b11 is reserved. A start with it leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | One-cycle start of an internal operation |
| op_kind | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| op_data | input | 8 | Byte being programmed |
| arr_rdata | input | 8 | Normal array read data |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| dq_out | output | 8 | Read data or status byte |
| dq_oe | output | 1 | Drive enable for the data bus |
| busy | output | 1 | Internal operation in progress |

## Verification
Program bytes with bit 7 set and with bit 7 clear show that the polling bit follows the written data and not a constant. Sector and chip erases show the fixed 0, and they are told apart only by their measured durations. Runs of two and three back-to-back busy reads separate a real per-read toggle from a level tied to busy. A second start with different kind and data during a program, and a start with the reserved kind, show that the latched values and the timing are left alone.

// File: rtl/fst_pkg.sv
package fst_pkg;
    typedef enum logic [1:0] {
        KIND_PROG = 2'b00,
        KIND_SECT = 2'b01,
        KIND_CHIP = 2'b10,
        KIND_RSVD = 2'b11
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_PROG  = 2'b01,
        ST_ERASE = 2'b10
    } fsm_state_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/fst_op_timer.sv
module fst_op_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8
endmodule

// File: rtl/fst_rd_edge.sv
module fst_rd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    output logic rd_act,
    output logic rd_end
);
    logic rd_prev_q;

    assign rd_act = !ce_n && !oe_n;

    always_ff @(posedge clk) begin
        if (!rst_n) rd_prev_q <= 1'b0;
        else        rd_prev_q <= rd_act;
    end

    assign rd_end = rd_prev_q && !rd_act;
endmodule

// File: rtl/fst_toggle.sv
module fst_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic step,
    output logic tgl
);
    always_ff @(posedge clk) begin
        if (!rst_n)    tgl <= 1'b1;
        else if (arm)  tgl <= 1'b1;
        else if (step) tgl <= !tgl;
    end

    AST_TGL_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> tgl); // R6
    AST_TGL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !arm) |=> (tgl != $past(tgl))); // R6
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fst_pkg::*;
#(
    parameter int PROG_CYCLES = 24,
    parameter int SECT_CYCLES = 64,
    parameter int CHIP_CYCLES = 160
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_start,
    input  logic [1:0] op_kind,
    input  logic [7:0] op_data,
    input  logic [7:0] arr_rdata,
    input  logic       ce_n,
    input  logic       oe_n,
    output logic [7:0] dq_out,
    output logic       dq_oe,
    output logic       busy
);
    localparam int MAX_A   = (PROG_CYCLES > SECT_CYCLES) ? PROG_CYCLES : SECT_CYCLES;
    localparam int MAX_DUR = (MAX_A > CHIP_CYCLES) ? MAX_A : CHIP_CYCLES;
    localparam int CNT_W   = $clog2(MAX_DUR + 1);

    fsm_state_e           state_q, state_d;
    op_kind_e             kind_in;
    logic                 accept;
    logic [CNT_W-1:0]     load_val;
    logic                 expired;
    logic                 rd_act, rd_end;
    logic                 tgl;
    logic [BYTE_W-1:0]    lat_data_q;
    op_kind_e             lat_kind_q;

    assign kind_in = op_kind_e'(op_kind);
    assign accept  = op_start && (state_q == ST_IDLE) && (kind_in != KIND_RSVD);

    always_comb begin
        unique case (kind_in)
            KIND_PROG: load_val = CNT_W'(PROG_CYCLES - 1);
            KIND_SECT: load_val = CNT_W'(SECT_CYCLES - 1);
            KIND_CHIP: load_val = CNT_W'(CHIP_CYCLES - 1);
            default:   load_val = '0;
        endcase
    end

    fst_op_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (load_val),
        .expired  (expired)
    );

    fst_rd_edge u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .rd_act (rd_act),
        .rd_end (rd_end)
    );

    fst_toggle u_tgl (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (accept),
        .step  (rd_end && (state_q != ST_IDLE)),
        .tgl   (tgl)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_data_q <= '0;
            lat_kind_q <= KIND_PROG;
        end else if (accept) begin
            lat_data_q <= op_data;
            lat_kind_q <= kind_in;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = (kind_in == KIND_PROG) ? ST_PROG : ST_ERASE;
            end
            ST_PROG, ST_ERASE: begin
                if (expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        dq_oe  = rd_act;
        busy   = 1'b0;
        dq_out = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_act) dq_out = arr_rdata;
            end
            ST_PROG: begin
                busy = 1'b1;
                if (rd_act) dq_out = {!lat_data_q[7], tgl, 6'b0};
            end
            ST_ERASE: begin
                busy = 1'b1;
                if (rd_act) dq_out = {1'b0, tgl, 6'b0};
            end
            default: ;
        endcase
    end

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy); // R8
    AST_IGNORED_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_start) |=> ($stable(lat_data_q) && $stable(lat_kind_q))); // R9
    AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && op_start && op_kind == 2'b11) |=> !busy); // R11
    AST_TGL_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && !accept) |=> $stable(tgl)); // R10
    AST_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> (!dq_oe && dq_out == 8'h00)); // R2
endmodule

// File: tb/sim_flash_status_gen.sv
module sim_flash_status_gen;
    localparam int P_CYC = 24;
    localparam int S_CYC = 64;
    localparam int C_CYC = 160;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_start = 1'b0;
    logic [1:0] op_kind = 2'b00;
    logic [7:0] op_data = 8'h00;
    logic [7:0] arr_rdata = 8'h00;
    logic       ce_n = 1'b1;
    logic       oe_n = 1'b1;
    logic [7:0] dq_out;
    logic       dq_oe;
    logic       busy;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    always #4 clk = !clk;
    always @(posedge clk) cyc <= cyc + 1;

    flash_status_gen #(.PROG_CYCLES(P_CYC), .SECT_CYCLES(S_CYC), .CHIP_CYCLES(C_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
        .op_data(op_data), .arr_rdata(arr_rdata), .ce_n(ce_n), .oe_n(oe_n),
        .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(output logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); d = dq_out; ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic start_op(input logic [1:0] k, input logic [7:0] d);
        @(negedge clk); op_start = 1'b1; op_kind = k; op_data = d;
        @(negedge clk); op_start = 1'b0;
    endtask

    task automatic wait_idle(output int spent, input int t0);
        int guard = 0;
        while (busy && guard < 1000) begin @(negedge clk); guard++; end
        spent = cyc - t0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 busy after reset", busy, 0);
        arr_rdata = 8'h5A;
        do_read(d);
        check("R1 read after reset", d, 8'h5A);
    endtask

    task automatic t_idle_read;
        logic [7:0] d;
        arr_rdata = 8'hC3; do_read(d); check("R3 idle read C3", d, 8'hC3);
        arr_rdata = 8'h18; do_read(d); check("R3 idle read 18", d, 8'h18);
    endtask

    task automatic t_program;
        logic [7:0] d; int t0, sp;
        arr_rdata = 8'hA5;
        start_op(2'b00, 8'h3C); t0 = cyc;
        do_read(d); check("R4 R6 R7 prog read1", d, 8'hC0);
        do_read(d); check("R6 prog read2", d, 8'h80);
        do_read(d); check("R6 prog read3", d, 8'hC0);
        wait_idle(sp, t0);
        check("R8 program duration", sp, P_CYC);
        arr_rdata = 8'h3C;
        do_read(d); check("R10 after prog read1", d, 8'h3C);
        do_read(d); check("R10 after prog read2", d, 8'h3C);
        start_op(2'b00, 8'hFF); t0 = cyc;
        do_read(d); check("R4 prog bit7 set", d, 8'h40);
        wait_idle(sp, t0);
    endtask

    task automatic t_erase(input logic [1:0] k, input int exp_len);
        logic [7:0] d; int t0, sp;
        arr_rdata = 8'h00;
        start_op(k, 8'h00); t0 = cyc;
        do_read(d); check("R5 erase read1", d, 8'h40);
        do_read(d); check("R5 R6 erase read2", d, 8'h00);
        wait_idle(sp, t0);
        check("R8 erase duration", sp, exp_len);
        arr_rdata = 8'hFF;
        do_read(d); check("R10 after erase", d, 8'hFF);
    endtask

    task automatic t_bus_release;
        int t0, sp;
        start_op(2'b01, 8'h00); t0 = cyc;
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        check("R2 oe high dq_oe", dq_oe, 0);
        check("R2 oe high dq_out", dq_out, 0);
        ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        check("R2 ce high dq_oe", dq_oe, 0);
        oe_n = 1'b1;
        wait_idle(sp, t0);
    endtask

    task automatic t_ignored_start;
        logic [7:0] d; int t0, sp;
        start_op(2'b00, 8'h00); t0 = cyc;
        start_op(2'b10, 8'hFF);
        do_read(d); check("R9 status kept", d, 8'hC0);
        wait_idle(sp, t0);
        check("R9 duration kept", sp, P_CYC);
    endtask

    task automatic t_reserved;
        logic [7:0] d;
        arr_rdata = 8'h77;
        start_op(2'b11, 8'h00);
        check("R11 reserved busy", busy, 0);
        do_read(d); check("R11 reserved read", d, 8'h77);
    endtask

    task automatic t_tgl_restart;
        logic [7:0] d; int t0, sp;
        start_op(2'b00, 8'h80); t0 = cyc;
        do_read(d); do_read(d);
        check("R6 toggle at 0", d, 8'h00);
        wait_idle(sp, t0);
        start_op(2'b01, 8'h00); t0 = cyc;
        do_read(d); check("R10 toggle restart", d, 8'h40);
        wait_idle(sp, t0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_read();
        t_program();
        t_erase(2'b01, S_CYC);
        t_erase(2'b10, C_CYC);
        t_bus_release();
        t_ignored_start();
        t_reserved();
        t_tgl_restart();
        finish_run();
    end

    initial begin
        #(8 * 200000);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end
endmodule